// File: doc/BRIEF.md
# Polarity-Aware Space-Vector Gate Sequencer

This block drives the six gates of a two-level three-phase inverter. Each carrier period is built from the two active vectors that bound the present 60-degree sector, plus zero-vector time. The sector number and the three dwell times arrive as inputs, in clock ticks. The block lays these out as a time-ordered chain of switching states. It also inserts a dead time on every leg transition.

Two layouts are offered. The symmetric layout opens and closes the period on the all-low zero vector and puts the all-high zero vector in the middle. The reduced common-mode layout uses a single zero vector, picked from the polarity of the supply half-cycle feeding the DC link. It uses all-low while the negative rail is tied to ground (positive half-cycle) and all-high while the positive rail is (negative half-cycle). This avoids the full-rail common-mode step while keeping the period length unchanged.

Alongside the gates, the block reports the index of the applied vector and its common-mode level in units of one third of the link voltage. The level follows from the count of legs tied high.

Top module: `cm_svpwm_seq`

## Requirements
- R1: The upper-gate pattern {a,b,c} per vector index is 0:000, 1:100, 2:110, 3:010, 4:011, 5:001, 6:101, 7:111 (bit 2 = leg a, bit 0 = leg c). `vec_idx` reports that index. Once a leg has settled, each lower gate is the inverse of its upper gate.
- R2: Sector k (1..6) uses Vk and V(k mod 6 + 1). The vector with one upper switch on (index 1, 3 or 5) comes first after the all-low zero vector. Its dwell is `t_one`, and the two-switch vector takes `t_two`. A sector code of 0 or 7 behaves as sector 1.
- R3: In the symmetric layout (`mode_rcm`=0) a period is Z0, A, B, Z7, B, A, Z0. Here A is the one-switch vector and B the two-switch vector. Each Z0 lasts floor(t_zero/4), and Z7 takes the rest of `t_zero`. The first A and B last floor(t/2), and the second ones take the remainder.
- R4: In the reduced layout with `pol_neg`=0 a period is Z0, A, B, A, Z0. It opens with floor(t_zero/2) of Z0 and closes with the rest. A is split floor-first, and B is applied whole.
- R5: In the reduced layout with `pol_neg`=1 a period is Z7, B, A, B, Z7. Z7 uses the same split as R4, B is split floor-first, and A is applied whole.
- R6: Every period lasts t_one + t_two + t_zero ticks in both layouts. Segments of zero length are skipped. A total of zero yields one-tick periods of the closing zero vector.
- R7: `cm_lvl` equals the number of upper switches on in the vector reported by `vec_idx` (0 to 3).
- R8: Sector, dwell, polarity and layout inputs are taken only on the edge that begins a period. A change mid-period first shows in the next period.
- R9: During reset and until the first period's first vector appears, `vec_idx` is 0, all upper gates are off and all lower gates are on.
- R10: When a leg's commanded state changes, both of its gates are off for exactly DEAD cycles before the new state is applied. Both gates of a leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sector | input | 3 | Sector number 1..6 |
| t_one | input | DW | Dwell of the one-switch active vector, ticks |
| t_two | input | DW | Dwell of the two-switch active vector, ticks |
| t_zero | input | DW | Total zero-vector dwell, ticks |
| pol_neg | input | 1 | 1 in the negative supply half-cycle |
| mode_rcm | input | 1 | 0 symmetric layout, 1 reduced common-mode layout |
| gate_hi | output | 3 | Upper gate commands, bit 2 = leg a |
| gate_lo | output | 3 | Lower gate commands, bit 2 = leg a |
| vec_idx | output | 3 | Index of the applied vector |
| cm_lvl | output | 2 | Common-mode level in units of Vdc/3 |

## Verification
The first period begins on the first rising edge after reset is released. Tick p of a period shows on `vec_idx` and `cm_lvl` after the edge one cycle later. A leg change on `vec_idx` turns both gates of that leg off one cycle after it, and the new state appears DEAD cycles after that. The bench's reference model advances on the rising edge in that same order: first gates, then the vector, then the period counter. It compares every output on the falling edge, so each expected value is due in the very cycle it is sampled. Input changes land on falling edges at random points in a period, which exercises the period-start sampling rule.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  typedef logic [2:0] legs_t;

  typedef enum logic {
    SEQ_SYM = 1'b0,
    SEQ_RCM = 1'b1
  } seq_mode_e;

  localparam int NSEG = 7;

  function automatic legs_t vec_pat(input logic [2:0] idx);
    case (idx)
      3'd0:    return 3'b000;
      3'd1:    return 3'b100;
      3'd2:    return 3'b110;
      3'd3:    return 3'b010;
      3'd4:    return 3'b011;
      3'd5:    return 3'b001;
      3'd6:    return 3'b101;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [2:0] pat_idx(input legs_t p);
    case (p)
      3'b000:  return 3'd0;
      3'b100:  return 3'd1;
      3'b110:  return 3'd2;
      3'b010:  return 3'd3;
      3'b011:  return 3'd4;
      3'b001:  return 3'd5;
      3'b101:  return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/svpwm_plan.sv
module svpwm_plan
  import svpwm_pkg::*;
#(
  parameter int DW = 12,
  parameter int PW = DW + 2
) (
  input  logic [2:0]                 sector,
  input  logic [DW-1:0]              t_one,
  input  logic [DW-1:0]              t_two,
  input  logic [DW-1:0]              t_zero,
  input  logic                       pol_neg,
  input  seq_mode_e                  mode,
  output legs_t [NSEG-1:0]           seg_vec,
  output logic [NSEG-1:0][PW-1:0]    seg_end,
  output logic [PW-1:0]              period_len
);

  logic [2:0]              v_one, v_two;
  logic                    rcm, neg;
  legs_t                   x_pat, y_pat, z_pat;
  logic [PW-1:0]           tx, ty, tz, zq, zh, acc;
  logic [NSEG-1:0][PW-1:0] len;

  always_comb begin
    case (sector)
      3'd2:    begin v_one = 3'd3; v_two = 3'd2; end
      3'd3:    begin v_one = 3'd3; v_two = 3'd4; end
      3'd4:    begin v_one = 3'd5; v_two = 3'd4; end
      3'd5:    begin v_one = 3'd5; v_two = 3'd6; end
      3'd6:    begin v_one = 3'd1; v_two = 3'd6; end
      default: begin v_one = 3'd1; v_two = 3'd2; end
    endcase

    rcm   = (mode == SEQ_RCM);
    neg   = rcm & pol_neg;
    x_pat = neg ? vec_pat(v_two) : vec_pat(v_one);
    y_pat = neg ? vec_pat(v_one) : vec_pat(v_two);
    z_pat = neg ? 3'b111 : 3'b000;
    tx    = PW'(neg ? t_two : t_one);
    ty    = PW'(neg ? t_one : t_two);
    tz    = PW'(t_zero);
    zq    = tz >> 2;
    zh    = tz >> 1;

    len[0] = rcm ? zh : zq;
    len[1] = tx >> 1;
    len[2] = rcm ? ty : (ty >> 1);
    len[3] = rcm ? '0 : (tz - (zq << 1));
    len[4] = rcm ? '0 : (ty - (ty >> 1));
    len[5] = tx - (tx >> 1);
    len[6] = rcm ? (tz - zh) : zq;

    seg_vec[0] = z_pat;
    seg_vec[1] = x_pat;
    seg_vec[2] = y_pat;
    seg_vec[3] = 3'b111;
    seg_vec[4] = y_pat;
    seg_vec[5] = x_pat;
    seg_vec[6] = z_pat;

    acc = '0;
    for (int i = 0; i < NSEG; i++) begin
      acc        = acc + len[i];
      seg_end[i] = acc;
    end
  end

  assign period_len = seg_end[NSEG-1];

endmodule

// File: rtl/svpwm_timebase.sv
module svpwm_timebase #(
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] period_len,
  output logic [PW-1:0] pos,
  output logic          run,
  output logic          start
);

  assign start = !run || (period_len == '0) || (pos == period_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      pos <= '0;
    end else if (start) begin
      run <= 1'b1;
      pos <= '0;
    end else begin
      pos <= pos + 1'b1;
    end
  end

endmodule

// File: rtl/svpwm_seg_pick.sv
module svpwm_seg_pick
  import svpwm_pkg::*;
#(
  parameter int PW = 14
) (
  input  logic                    run,
  input  logic [PW-1:0]           pos,
  input  legs_t [NSEG-1:0]        seg_vec,
  input  logic [NSEG-1:0][PW-1:0] seg_end,
  output legs_t                   vec
);

  always_comb begin
    vec = seg_vec[NSEG-1];
    for (int i = NSEG - 1; i >= 0; i--) begin
      if (pos < seg_end[i]) vec = seg_vec[i];
    end
    if (!run) vec = 3'b000;
  end

endmodule

// File: rtl/svpwm_deadband.sv
module svpwm_deadband #(
  parameter int DEAD = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cmd,
  output logic [2:0] hi,
  output logic [2:0] lo
);

  localparam int CW = (DEAD > 1) ? $clog2(DEAD) : 1;

  for (genvar g = 0; g < 3; g++) begin : g_leg
    logic hi_r, lo_r;
    assign hi[g] = hi_r;
    assign lo[g] = lo_r;

    if (DEAD == 0) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) begin
          hi_r <= 1'b0;
          lo_r <= 1'b1;
        end else begin
          hi_r <= cmd[g];
          lo_r <= ~cmd[g];
        end
      end
    end else begin : g_hold
      logic          cur;
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cur  <= 1'b0;
          cnt  <= '0;
          hi_r <= 1'b0;
          lo_r <= 1'b1;
        end else if (cmd[g] != cur) begin
          cur  <= cmd[g];
          cnt  <= CW'(DEAD - 1);
          hi_r <= 1'b0;
          lo_r <= 1'b0;
        end else if (cnt != '0) begin
          cnt  <= cnt - 1'b1;
          hi_r <= 1'b0;
          lo_r <= 1'b0;
        end else begin
          hi_r <= cur;
          lo_r <= ~cur;
        end
      end
    end
  end

endmodule

// File: rtl/cm_svpwm_seq.sv
module cm_svpwm_seq
  import svpwm_pkg::*;
#(
  parameter int DW   = 12,
  parameter int DEAD = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    sector,
  input  logic [DW-1:0] t_one,
  input  logic [DW-1:0] t_two,
  input  logic [DW-1:0] t_zero,
  input  logic          pol_neg,
  input  logic          mode_rcm,
  output logic [2:0]    gate_hi,
  output logic [2:0]    gate_lo,
  output logic [2:0]    vec_idx,
  output logic [1:0]    cm_lvl
);

  localparam int PW = DW + 2;

  logic [2:0]              sec_q;
  logic [DW-1:0]           t1_q, t2_q, tz_q;
  logic                    pol_q;
  seq_mode_e               mode_q;
  legs_t [NSEG-1:0]        seg_vec;
  logic [NSEG-1:0][PW-1:0] seg_end;
  logic [PW-1:0]           period_len, pos;
  logic                    run, start;
  legs_t                   vec_d, vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= 3'd1;
      t1_q   <= '0;
      t2_q   <= '0;
      tz_q   <= '0;
      pol_q  <= 1'b0;
      mode_q <= SEQ_SYM;
    end else if (start) begin
      sec_q  <= sector;
      t1_q   <= t_one;
      t2_q   <= t_two;
      tz_q   <= t_zero;
      pol_q  <= pol_neg;
      mode_q <= seq_mode_e'(mode_rcm);
    end
  end

  svpwm_plan #(.DW(DW), .PW(PW)) u_plan (
    .sector     (sec_q),
    .t_one      (t1_q),
    .t_two      (t2_q),
    .t_zero     (tz_q),
    .pol_neg    (pol_q),
    .mode       (mode_q),
    .seg_vec    (seg_vec),
    .seg_end    (seg_end),
    .period_len (period_len)
  );

  svpwm_timebase #(.PW(PW)) u_tbase (
    .clk        (clk),
    .rst        (rst),
    .period_len (period_len),
    .pos        (pos),
    .run        (run),
    .start      (start)
  );

  svpwm_seg_pick #(.PW(PW)) u_pick (
    .run     (run),
    .pos     (pos),
    .seg_vec (seg_vec),
    .seg_end (seg_end),
    .vec     (vec_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q   <= 3'b000;
      vec_idx <= 3'd0;
      cm_lvl  <= 2'd0;
    end else begin
      vec_q   <= vec_d;
      vec_idx <= pat_idx(vec_d);
      cm_lvl  <= 2'(vec_d[0]) + 2'(vec_d[1]) + 2'(vec_d[2]);
    end
  end

  svpwm_deadband #(.DEAD(DEAD)) u_dead (
    .clk (clk),
    .rst (rst),
    .cmd (vec_q),
    .hi  (gate_hi),
    .lo  (gate_lo)
  );

endmodule

// File: rtl/cm_svpwm_seq_chk.sv
module cm_svpwm_seq_chk
  import svpwm_pkg::*;
#(
  parameter int DEAD = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo,
  input logic [2:0] vec_idx,
  input logic [1:0] cm_lvl
);

  localparam int SW = $clog2(DEAD + 1) + 1;

  logic [2:0]    prev_idx;
  logic [SW-1:0] stab;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_idx <= 3'd0;
      stab     <= SW'(DEAD);
    end else begin
      prev_idx <= vec_idx;
      if (vec_idx != prev_idx) stab <= '0;
      else if (stab < SW'(DEAD)) stab <= stab + 1'b1;
    end
  end

  // R10
  legs_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == 3'b000);

  // R1
  settled_gates_chk: assert property (@(posedge clk) disable iff (rst)
    (stab == SW'(DEAD) && vec_idx == prev_idx) |->
      (gate_hi == vec_pat(vec_idx) && gate_lo == ~vec_pat(vec_idx)));

  // R7
  cm_level_chk: assert property (@(posedge clk) disable iff (rst)
    cm_lvl == 2'($countones(vec_pat(vec_idx))));

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (vec_idx == 3'd0 && gate_hi == 3'b000 && gate_lo == 3'b111));

endmodule

bind cm_svpwm_seq cm_svpwm_seq_chk #(.DEAD(DEAD)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .gate_hi (gate_hi),
  .gate_lo (gate_lo),
  .vec_idx (vec_idx),
  .cm_lvl  (cm_lvl)
);

// File: tb/sim_cm_svpwm_seq.sv
module sim_cm_svpwm_seq;

  localparam int DW   = 12;
  localparam int DEAD = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    sector = 3'd1;
  logic [DW-1:0] t_one = '0, t_two = '0, t_zero = '0;
  logic          pol_neg = 1'b0, mode_rcm = 1'b0;
  logic [2:0]    gate_hi, gate_lo, vec_idx;
  logic [1:0]    cm_lvl;

  cm_svpwm_seq #(.DW(DW), .DEAD(DEAD)) u0 (
    .clk(clk), .rst(rst), .sector(sector), .t_one(t_one), .t_two(t_two),
    .t_zero(t_zero), .pol_neg(pol_neg), .mode_rcm(mode_rcm),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .vec_idx(vec_idx), .cm_lvl(cm_lvl)
  );

  always #5 clk = ~clk;

  int    checks = 0, errors = 0, cyc = 0;
  string tag = "R9";
  bit    chk_on = 1'b0;

  function automatic int pat_of(input int idx);
    case (idx)
      0: return 0;      1: return 4;   2: return 6;   3: return 2;
      4: return 3;      5: return 1;   6: return 5;   default: return 7;
    endcase
  endfunction

  // expected vector index at tick p of a period, from R2..R6
  function automatic int exp_vec_at(input int p, input int sec, input int t1,
                                    input int t2, input int tz, input bit pol,
                                    input bit md);
    int vo, ve, x, y, z, tx, ty, acc;
    int len[7];
    int v[7];
    bit ng;
    case (sec)
      2: begin vo = 3; ve = 2; end
      3: begin vo = 3; ve = 4; end
      4: begin vo = 5; ve = 4; end
      5: begin vo = 5; ve = 6; end
      6: begin vo = 1; ve = 6; end
      default: begin vo = 1; ve = 2; end
    endcase
    ng = md && pol;
    x  = ng ? ve : vo;  y  = ng ? vo : ve;  z = ng ? 7 : 0;
    tx = ng ? t2 : t1;  ty = ng ? t1 : t2;
    if (md) begin
      len[0] = tz / 2; len[1] = tx / 2; len[2] = ty; len[3] = 0;
      len[4] = 0; len[5] = tx - tx / 2; len[6] = tz - tz / 2;
    end else begin
      len[0] = tz / 4; len[1] = tx / 2; len[2] = ty / 2;
      len[3] = tz - 2 * (tz / 4); len[4] = ty - ty / 2;
      len[5] = tx - tx / 2; len[6] = tz / 4;
    end
    v[0] = z; v[1] = x; v[2] = y; v[3] = 7; v[4] = y; v[5] = x; v[6] = z;
    acc = 0;
    for (int i = 0; i < 7; i++) begin
      acc = acc + len[i];
      if (p < acc) return v[i];
    end
    return v[6];
  endfunction

  // reference model, advanced on the rising edge
  int         m_pos, m_len, m_sec, m_t1, m_t2, m_tz;
  bit         m_run, m_pol, m_md;
  int         e_idx;
  int         g_off[3];
  bit         g_cur[3];
  logic [2:0] e_hi, e_lo;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_pos = 0; m_len = 0; e_idx = 0;
      m_sec = 1; m_t1 = 0; m_t2 = 0; m_tz = 0; m_pol = 0; m_md = 0;
      e_hi = 3'b000; e_lo = 3'b111;
      for (int i = 0; i < 3; i++) begin g_off[i] = 0; g_cur[i] = 0; end
    end else begin
      int pt, nidx;
      pt = pat_of(e_idx);
      for (int i = 0; i < 3; i++) begin
        bit b;
        b = pt[i];
        if (b != g_cur[i]) begin g_cur[i] = b; g_off[i] = DEAD; end
        if (g_off[i] > 0) begin
          e_hi[i] = 1'b0; e_lo[i] = 1'b0; g_off[i] = g_off[i] - 1;
        end else begin
          e_hi[i] = g_cur[i]; e_lo[i] = !g_cur[i];
        end
      end
      nidx = m_run ? exp_vec_at(m_pos, m_sec, m_t1, m_t2, m_tz, m_pol, m_md) : 0;
      if (!m_run || m_len == 0 || m_pos == m_len - 1) begin
        m_sec = int'(sector); m_t1 = int'(t_one); m_t2 = int'(t_two);
        m_tz = int'(t_zero); m_pol = pol_neg; m_md = mode_rcm;
        m_len = m_t1 + m_t2 + m_tz; m_pos = 0; m_run = 1;
      end else begin
        m_pos = m_pos + 1;
      end
      e_idx = nidx;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(int'(vec_idx) == e_idx, tag, "vec_idx", int'(vec_idx), e_idx);
      // R7: level = number of upper switches on
      chk(int'(cm_lvl) == $countones(pat_of(e_idx)), "R7", "cm_lvl",
          int'(cm_lvl), $countones(pat_of(e_idx)));
      chk(gate_hi == e_hi, "R1/R10", "gate_hi", int'(gate_hi), int'(e_hi));
      chk(gate_lo == e_lo, "R1/R10", "gate_lo", int'(gate_lo), int'(e_lo));
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL R8 watchdog: actual %0d cycles expected below %0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic drive(input int s, input int a, input int b, input int z,
                       input bit pn, input bit md);
    sector = 3'(s); t_one = DW'(a); t_two = DW'(b); t_zero = DW'(z);
    pol_neg = pn; mode_rcm = md;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    hold(3);
    // R9: reset state
    chk(vec_idx == 3'd0, "R9", "vec_idx in reset", int'(vec_idx), 0);
    chk(gate_hi == 3'b000, "R9", "gate_hi in reset", int'(gate_hi), 0);
    chk(gate_lo == 3'b111, "R9", "gate_lo in reset", int'(gate_lo), 7);
    rst = 1'b0;
    chk_on = 1'b1;
    tag = "R3";  drive(1, 6, 4, 9, 0, 0);  hold(60);
    tag = "R3";  drive(1, 7, 5, 3, 1, 0);  hold(45);
    tag = "R4";  drive(1, 5, 7, 7, 0, 1);  hold(60);
    tag = "R5";  drive(1, 5, 7, 7, 1, 1);  hold(60);
    tag = "R2";
    for (int s = 0; s < 8; s++) begin drive(s, 4, 6, 5, 0, 0); hold(32); end
    for (int s = 1; s < 7; s++) begin drive(s, 3, 5, 6, 1, 1); hold(28); end
    tag = "R6";  drive(3, 0, 0, 0, 0, 0);  hold(8);
    drive(3, 0, 0, 0, 1, 1);  hold(8);
    drive(4, 1, 0, 0, 0, 1);  hold(8);
    for (int k = 0; k < 12; k++) begin
      drive(2, 3, 5, 8, k[0], k[1]); hold(16);
    end
    tag = "R8";
    for (int k = 0; k < 400; k++) begin
      drive(int'($urandom_range(1, 6)), int'($urandom_range(0, 15)),
            int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      hold(int'($urandom_range(1, 40)));
    end
    chk_on = 1'b0;
    finish_run();
  end

endmodule